// File: doc/BRIEF.md
# Prefixed Shift, Rotate and Bit-Manipulation Unit

This block executes the eight-bit instruction group reached through the shift/bit prefix byte of an 8-bit microprocessor. Each cycle in which `op_valid` is high, it takes an operand byte, the second opcode byte and the current flag byte. One clock later it returns the result byte, a write-back enable and the new flag byte. The second opcode byte is read in octal as `g p r`. Group `g` = 0 selects one of eight shifts or rotates `p` on register field `r`. Group 1 tests bit `p`, group 2 clears bit `p` and group 3 sets bit `p`.

Slot `p` = 6 of the shift group holds the shift-left-and-set operation. The unit also handles the indexed four-byte encoding: index prefix, shift/bit prefix, displacement, final opcode. A sequencer marks an opcode of that form with `op_indexed`. When the register field is not 6, the unit flags an extra copy of the memory result into register `r`. This copy adds no cycles. Fetching operands from memory and instruction sequencing are done outside the block.

Top module: `cbx_unit`

## Requirements
- R1: Circular rotates. p=0 rotates left, with old bit 7 entering bit 0 and carry. p=1 rotates right, with old bit 0 entering bit 7 and carry.
- R2: Rotates through carry. p=2 shifts left with carry-in entering bit 0 and old bit 7 going to carry. p=3 shifts right with carry-in entering bit 7 and old bit 0 going to carry.
- R3: Plain shifts. p=4 shifts left with a 0 entering bit 0 and carry taking old bit 7. p=5 shifts right keeping bit 7, with carry taking old bit 0. p=7 shifts right with a 0 entering bit 7, with carry taking old bit 0.
- R4: p=6 shifts left, forces bit 0 of the result to 1 and puts old bit 7 into carry.
- R5: Flag byte layout is bit5 S, bit4 Z, bit3 H, bit2 PV, bit1 N, bit0 C. After any shift or rotate: S = result bit 7, Z = 1 if the result is zero, H = 0, N = 0, and PV = 1 when the result has an even number of ones.
- R6: Group 1 (bit test) sets Z to the inverse of operand bit p, H = 1 and N = 0, and keeps S, PV and C. It returns the operand unchanged with the write-back enable low.
- R7: Group 2 clears bit p and group 3 sets bit p of the operand. Write-back is enabled and the flag byte passes through unchanged.
- R8: `res_reg_copy` is high only for an indexed opcode whose register field is not 6 and whose group is not 1. `res_reg_sel` always carries the register field.
- R9: Results appear exactly one cycle after `op_valid`. `res_valid` is low in a cycle with no request and after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Request strobe |
| op_code | input | 8 | Second (final) opcode byte, octal g p r |
| op_indexed | input | 1 | Opcode came from the indexed four-byte form |
| op_data | input | 8 | Operand byte |
| op_flags | input | 6 | Current flags {S,Z,H,PV,N,C} |
| res_valid | output | 1 | Result strobe |
| res_data | output | 8 | Result byte |
| res_wb | output | 1 | Result must be written back |
| res_flags | output | 6 | New flags {S,Z,H,PV,N,C} |
| res_reg_copy | output | 1 | Also copy the result into register res_reg_sel |
| res_reg_sel | output | 3 | Register field of the opcode |

## Verification
The bench targets the values where bit 7 or bit 0 leaves the byte. Shifting 0x80 left must give a zero result with carry set. A unit that fed the fill bit wrongly would keep the top bit or lose carry. Slot 6 is checked on 0x00 and 0x80, where a design that treated it as a plain left shift returns a result with bit 0 clear. Bit tests with carry set in the incoming flags expose a unit that disturbs carry or writes back. Indexed opcodes are checked with register field 6, with another register field and with a bit test, so a copy flag decoded from the wrong field or group shows up.

// File: rtl/cbx_pkg.sv
package cbx_pkg;
  typedef enum logic [1:0] {
    GRP_SHIFT = 2'd0,
    GRP_TEST  = 2'd1,
    GRP_CLR   = 2'd2,
    GRP_SETB  = 2'd3
  } grp_e;

  localparam int FL_C  = 0;
  localparam int FL_N  = 1;
  localparam int FL_PV = 2;
  localparam int FL_H  = 3;
  localparam int FL_Z  = 4;
  localparam int FL_S  = 5;
  localparam int FL_W  = 6;

  localparam logic [2:0] MEM_FIELD = 3'd6;

  function automatic logic even_ones(input logic [7:0] v);
    return ~^v;
  endfunction

  // returns {carry_out, result}
  function automatic logic [8:0] shift_calc(input logic [2:0] p,
                                            input logic [7:0] a,
                                            input logic cin);
    logic [8:0] o;
    case (p)
      3'd0:    o = {a[7], a[6:0], a[7]};
      3'd1:    o = {a[0], a[0], a[7:1]};
      3'd2:    o = {a[7], a[6:0], cin};
      3'd3:    o = {a[0], cin, a[7:1]};
      3'd4:    o = {a[7], a[6:0], 1'b0};
      3'd5:    o = {a[0], a[7], a[7:1]};
      3'd6:    o = {a[7], a[6:0], 1'b1};
      default: o = {a[0], 1'b0, a[7:1]};
    endcase
    return o;
  endfunction
endpackage

// File: rtl/cbx_decode.sv
module cbx_decode
  import cbx_pkg::*;
(
  input  logic [7:0] code,
  input  logic       indexed,
  output grp_e       grp,
  output logic [2:0] sel_p,
  output logic [2:0] sel_r,
  output logic       reg_copy
);
  always_comb begin
    grp      = grp_e'(code[7:6]);
    sel_p    = code[5:3];
    sel_r    = code[2:0];
    reg_copy = indexed && (code[2:0] != MEM_FIELD) && (code[7:6] != 2'd1);
  end
endmodule

// File: rtl/cbx_shift.sv
module cbx_shift
  import cbx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [2:0]        sel_p,
  input  logic [DATA_W-1:0] a,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  logic [8:0] calc;
  always_comb begin
    calc = shift_calc(sel_p, a, cin);
    res  = calc[DATA_W-1:0];
    cout = calc[8];
  end
endmodule

// File: rtl/cbx_bitop.sv
module cbx_bitop #(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] a,
  input  logic              set_mode,
  output logic [DATA_W-1:0] res,
  output logic              tested
);
  logic [DATA_W-1:0] mask;
  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign mask[i] = (idx == IDX_W'(i));
  end
  assign res    = set_mode ? (a | mask) : (a & ~mask);
  assign tested = |(a & mask);
endmodule

// File: rtl/cbx_unit.sv
module cbx_unit
  import cbx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [7:0]        op_code,
  input  logic              op_indexed,
  input  logic [DATA_W-1:0] op_data,
  input  logic [FL_W-1:0]   op_flags,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic              res_wb,
  output logic [FL_W-1:0]   res_flags,
  output logic              res_reg_copy,
  output logic [2:0]        res_reg_sel
);
  grp_e              grp;
  logic [2:0]        sel_p, sel_r;
  logic              copy_d;
  logic [DATA_W-1:0] sh_res, bo_res;
  logic              sh_c, bo_tested;
  logic [DATA_W-1:0] nxt_data;
  logic [FL_W-1:0]   nxt_flags;
  logic              nxt_wb;

  cbx_decode u_dec (
    .code(op_code), .indexed(op_indexed), .grp(grp),
    .sel_p(sel_p), .sel_r(sel_r), .reg_copy(copy_d)
  );

  cbx_shift #(.DATA_W(DATA_W)) u_sh (
    .sel_p(sel_p), .a(op_data), .cin(op_flags[FL_C]),
    .res(sh_res), .cout(sh_c)
  );

  cbx_bitop #(.DATA_W(DATA_W)) u_bo (
    .idx(sel_p), .a(op_data), .set_mode(grp == GRP_SETB),
    .res(bo_res), .tested(bo_tested)
  );

  always_comb begin
    nxt_data  = op_data;
    nxt_flags = op_flags;
    nxt_wb    = 1'b1;
    case (grp)
      GRP_SHIFT: begin
        nxt_data          = sh_res;
        nxt_flags[FL_S]   = sh_res[DATA_W-1];
        nxt_flags[FL_Z]   = (sh_res == '0);
        nxt_flags[FL_H]   = 1'b0;
        nxt_flags[FL_PV]  = even_ones(sh_res);
        nxt_flags[FL_N]   = 1'b0;
        nxt_flags[FL_C]   = sh_c;
      end
      GRP_TEST: begin
        nxt_wb          = 1'b0;
        nxt_flags[FL_Z] = ~bo_tested;
        nxt_flags[FL_H] = 1'b1;
        nxt_flags[FL_N] = 1'b0;
      end
      default: nxt_data = bo_res;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      res_data     <= '0;
      res_wb       <= 1'b0;
      res_flags    <= '0;
      res_reg_copy <= 1'b0;
      res_reg_sel  <= '0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) begin
        res_data     <= nxt_data;
        res_wb       <= nxt_wb;
        res_flags    <= nxt_flags;
        res_reg_copy <= copy_d;
        res_reg_sel  <= sel_r;
      end
    end
  end

  // Named events for the assertions
  logic was_shift, was_test, was_bitwr, was_sls;
  assign was_shift = op_valid && (op_code[7:6] == 2'd0);
  assign was_test  = op_valid && (op_code[7:6] == 2'd1);
  assign was_bitwr = op_valid && op_code[7];
  assign was_sls   = was_shift && (op_code[5:3] == 3'd6);

  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);
  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !res_valid);
  assert_sls_bit0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    was_sls |=> (res_data[0] && res_flags[FL_C] == $past(op_data[DATA_W-1])));
  assert_shift_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    was_shift |=> (!res_flags[FL_H] && !res_flags[FL_N] &&
                   res_flags[FL_Z] == (res_data == '0)));
  assert_test_nowrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
    was_test |=> (!res_wb && res_flags[FL_H] &&
                  res_flags[FL_C] == $past(op_flags[FL_C]) &&
                  res_data == $past(op_data)));
  assert_bitwr_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    was_bitwr |=> (res_wb && res_flags == $past(op_flags)));
  assert_copy_field_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_reg_copy |-> (res_wb && res_reg_sel != MEM_FIELD));
endmodule

// File: tb/cbx_unit_tb.sv
module cbx_unit_tb_top;
  typedef struct {
    logic [7:0] data;
    logic       wb;
    logic [5:0] flags;
    logic       copy;
    logic [2:0] sel;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [7:0] op_code = '0;
  logic op_indexed = 1'b0;
  logic [7:0] op_data = '0;
  logic [5:0] op_flags = '0;
  logic res_valid, res_wb, res_reg_copy;
  logic [7:0] res_data;
  logic [5:0] res_flags;
  logic [2:0] res_reg_sel;

  int tests = 0;
  int fails = 0;
  exp_t sb[$];
  bit done = 1'b0;

  always #5 clk = ~clk;

  cbx_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_indexed(op_indexed), .op_data(op_data), .op_flags(op_flags),
    .res_valid(res_valid), .res_data(res_data), .res_wb(res_wb),
    .res_flags(res_flags), .res_reg_copy(res_reg_copy),
    .res_reg_sel(res_reg_sel)
  );

  function automatic exp_t model(input logic [7:0] code, input logic [7:0] a,
                                 input logic [5:0] f, input logic idx,
                                 input string tag);
    exp_t e;
    logic [1:0] g = code[7:6];
    logic [2:0] p = code[5:3];
    logic fill;
    int ones = 0;
    e.tag = tag; e.sel = code[2:0]; e.data = a; e.wb = 1'b1; e.flags = f;
    e.copy = idx && (code[2:0] != 3'd6) && (g != 2'd1);
    if (g == 2'd0) begin
      if (p[0] == 1'b0) begin
        fill = (p == 3'd0) ? a[7] : (p == 3'd2) ? f[0] : (p == 3'd6);
        {e.flags[0], e.data} = {a, fill};
      end else begin
        fill = (p == 3'd1) ? a[0] : (p == 3'd3) ? f[0] :
               (p == 3'd5) ? a[7] : 1'b0;
        {e.data, e.flags[0]} = {fill, a};
      end
      for (int i = 0; i < 8; i++) ones += int'(e.data[i]);
      e.flags[5] = e.data[7];
      e.flags[4] = (e.data == 8'h00);
      e.flags[3] = 1'b0;
      e.flags[2] = (ones % 2 == 0);
      e.flags[1] = 1'b0;
    end else if (g == 2'd1) begin
      e.wb = 1'b0;
      e.flags[4] = ~a[p];
      e.flags[3] = 1'b1;
      e.flags[1] = 1'b0;
    end else begin
      e.data[p] = (g == 2'd3);
    end
    return e;
  endfunction

  task automatic drive(input logic [7:0] code, input logic [7:0] a,
                       input logic [5:0] f, input logic idx, input string tag);
    @(negedge clk);
    op_valid = 1'b1; op_code = code; op_data = a; op_flags = f; op_indexed = idx;
    sb.push_back(model(code, a, f, idx, tag));
  endtask

  task automatic idle();
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      exp_t e;
      tests++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL R9: result with nothing expected (data %h)", res_data);
      end else begin
        e = sb.pop_front();
        if (res_data !== e.data || res_wb !== e.wb || res_flags !== e.flags ||
            res_reg_copy !== e.copy || res_reg_sel !== e.sel) begin
          fails++;
          $display("FAIL %s: got d=%h wb=%b f=%b cp=%b sel=%0d exp d=%h wb=%b f=%b cp=%b sel=%0d",
                   e.tag, res_data, res_wb, res_flags, res_reg_copy, res_reg_sel,
                   e.data, e.wb, e.flags, e.copy, e.sel);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    tests++;
    if (res_valid !== 1'b0) begin
      fails++;
      $display("FAIL R9: reset res_valid got %b exp 0", res_valid);
    end
    rst_n = 1'b1;
    // R1 circular rotates
    drive(8'o007, 8'h81, 6'b000000, 1'b0, "R1");
    drive(8'o010, 8'h01, 6'b000000, 1'b0, "R1");
    // R2 through carry
    drive(8'o020, 8'h80, 6'b000001, 1'b0, "R2");
    drive(8'o031, 8'h02, 6'b000001, 1'b0, "R2");
    // R3 shifts
    drive(8'o040, 8'h80, 6'b000000, 1'b0, "R3");
    drive(8'o051, 8'h81, 6'b000000, 1'b0, "R3");
    drive(8'o072, 8'h01, 6'b111111, 1'b0, "R3");
    // R4 shift-left-set
    drive(8'o067, 8'h80, 6'b000000, 1'b0, "R4");
    drive(8'o063, 8'h00, 6'b000001, 1'b0, "R4");
    // R5 parity / sign
    drive(8'o040, 8'hC1, 6'b001010, 1'b0, "R5");
    // R6 bit test
    drive(8'o177, 8'h7F, 6'b100101, 1'b0, "R6");
    drive(8'o100, 8'h01, 6'b010011, 1'b0, "R6");
    // R7 clear / set
    drive(8'o233, 8'hFF, 6'b101010, 1'b0, "R7");
    drive(8'o350, 8'h00, 6'b010101, 1'b0, "R7");
    // R8 indexed forms
    drive(8'o006, 8'h40, 6'b000000, 1'b1, "R8");
    drive(8'o062, 8'h40, 6'b000000, 1'b1, "R8");
    drive(8'o142, 8'h40, 6'b000001, 1'b1, "R8");
    drive(8'o322, 8'h40, 6'b000000, 1'b1, "R8");
    drive(8'o322, 8'h40, 6'b000000, 1'b0, "R8");
    idle();
    @(negedge clk);
    tests++;
    if (res_valid !== 1'b0) begin
      fails++;
      $display("FAIL R9: idle res_valid got %b exp 0", res_valid);
    end
    tests++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R9: %0d results missing exp 0", sb.size());
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        tests++; fails++;
        $display("FAIL R9: watchdog expired got hang exp completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule